// File: doc/BRIEF.md
# Stack Core ALU with Masked Flag Write

This block is the arithmetic and flag datapath of a small 16-bit stack machine. Each cycle in which `in_valid` is high, it takes a 5-bit command code, two operands and the core's current flag word. One clock later it presents the registered result, the flag word the core should keep, a flag write strobe and an illegal-command indication. It implements add and subtract with a carry/borrow flag, the bitwise operations, one-bit shifts, byte swap, byte sign extension, a plain copy, and access to the flag word and to two pointer registers (stack and base) that live inside the block.

The flag word is written through a bit mask. Each bit of the second operand that is 1 keeps the old flag bit, and each bit that is 0 takes the matching bit of the first operand. The upper byte of the flag word is reserved and is always written as zero. Any code this block does not implement is reported as illegal, gives a zero result and leaves the flags alone.

Top module: `stk_alu`

## Requirements
- R1: Outputs are registered: `out_valid` equals `in_valid` from the previous cycle. After synchronous reset, `out_valid`, `result`, `flags_we` and `illegal` are 0, and both pointer registers read 0.
- R2: Command 16 (add) returns `(opa+opb) mod 2^16` and sets carry (flag bit 2) to the unsigned carry out. `flags_out` is `flags_in` with bit 2 replaced, and `flags_we`=1.
- R3: Command 17 (sub) returns `(opa-opb) mod 2^16` and sets carry (bit 2) to 1 exactly when `opa < opb` unsigned. `flags_out` is `flags_in` with bit 2 replaced, and `flags_we`=1.
- R4: Command 0 returns `opa`. 21 returns `opa&opb`, 22 `opa|opb`, 23 `opa^opb` and 24 `~opa`.
- R5: Command 28 exchanges the two bytes of `opa`. Command 25 returns the low byte of `opa` with bit 7 of `opa` copied into all of bits 15:8.
- R6: Command 30 shifts `opa` left by one bit and command 31 shifts it right by one bit. The vacated bit is 0.
- R7: Command 11 (flag set) computes `(flags_in & opb) | (opa & ~opb)`, forces bits 15:8 to 0, and gives this value on both `result` and `flags_out` with `flags_we`=1. Flag layout: bit 0 zero, 1 negative, 2 carry, 3 carry enable, 7:4 interrupt enables.
- R8: Command 10 (flag get) returns `flags_in` as the result.
- R9: Command 15 loads the stack pointer from `opa` and command 13 loads the base pointer from `opa`. Both return `opa`. Commands 14 and 12 return the stack and base pointer as loaded by earlier commands.
- R10: Codes 1–9, 18–20, 26, 27 and 29 raise `illegal`, give `result`=0 and `flags_we`=0, and alter no pointer.
- R11: For every command other than add, sub and flag set, `flags_we`=0 and `flags_out` equals the `flags_in` presented with that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command present this cycle |
| cmd | input | 5 | Command code |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand / flag keep mask |
| flags_in | input | 16 | Current flag word of the core |
| out_valid | output | 1 | Registered result valid |
| result | output | 16 | Registered result |
| flags_out | output | 16 | Flag word to keep after the command |
| flags_we | output | 1 | Flag word changed by this command |
| illegal | output | 1 | Command code not implemented here |

## Verification
The assertions assume that `in_valid`, `cmd`, the operands and `flags_in` are known values at every clock edge and change only between edges. The flag-hold check relates `flags_out` to the `flags_in` of the previous cycle. The bench therefore drives all inputs from their declared zero values at time zero and changes them only on falling edges. Random stimulus spans the full 5-bit code space, so that illegal codes are mixed with pointer writes and flag merges. Reset is held for several edges before any command, so the pointer-load check never compares against a command issued during reset.

// File: rtl/stk_alu_pkg.sv
package stk_alu_pkg;
  typedef enum logic [4:0] {
    OP_MOV   = 5'd0,
    OP_FRGET = 5'd10,
    OP_FRSET = 5'd11,
    OP_BPGET = 5'd12,
    OP_BPSET = 5'd13,
    OP_SPGET = 5'd14,
    OP_SPSET = 5'd15,
    OP_ADD   = 5'd16,
    OP_SUB   = 5'd17,
    OP_AND   = 5'd21,
    OP_OR    = 5'd22,
    OP_XOR   = 5'd23,
    OP_INV   = 5'd24,
    OP_SEXT  = 5'd25,
    OP_SWAP  = 5'd28,
    OP_SHL   = 5'd30,
    OP_SHR   = 5'd31
  } op_e;

  localparam int FLG_CARRY = 2;
  localparam int FLG_USED  = 8;
  localparam int PTR_SP    = 0;
  localparam int PTR_BP    = 1;
  localparam int PTR_CNT   = 2;
endpackage

// File: rtl/stk_alu_bitops.sv
module stk_alu_bitops
  import stk_alu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [4:0]    cmd,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res,
  output logic          hit
);
  localparam int HB = DW / 2;

  always_comb begin
    hit = 1'b1;
    res = '0;
    case (op_e'(cmd))
      OP_MOV:  res = a;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_INV:  res = ~a;
      OP_SEXT: res = {{(DW-HB){a[HB-1]}}, a[HB-1:0]};
      OP_SWAP: res = {a[HB-1:0], a[DW-1:HB]};
      OP_SHL:  res = {a[DW-2:0], 1'b0};
      OP_SHR:  res = {1'b0, a[DW-1:1]};
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/stk_alu_addsub.sv
module stk_alu_addsub #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output logic          cout
);
  logic [DW:0] wide;

  always_comb begin
    if (sub) wide = {1'b0, a} - {1'b0, b};
    else     wide = {1'b0, a} + {1'b0, b};
    sum  = wide[DW-1:0];
    cout = wide[DW];
  end

  // R2 R3
  always_comb begin
    carry_rel_chk: assert (cout == (sub ? (a < b) : (sum < a)));
  end
endmodule

// File: rtl/stk_alu_flags.sv
module stk_alu_flags
  import stk_alu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] flags_in,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] keep,
  input  logic          do_merge,
  input  logic          do_carry,
  input  logic          carry,
  output logic [DW-1:0] flags_nxt,
  output logic [DW-1:0] merged,
  output logic          we
);
  localparam logic [DW-1:0] USED_MASK = {{(DW-FLG_USED){1'b0}}, {FLG_USED{1'b1}}};

  always_comb begin
    merged    = ((flags_in & keep) | (a & ~keep)) & USED_MASK;
    flags_nxt = flags_in;
    we        = 1'b0;
    if (do_merge) begin
      flags_nxt = merged;
      we        = 1'b1;
    end else if (do_carry) begin
      flags_nxt[FLG_CARRY] = carry;
      we                   = 1'b1;
    end
  end
endmodule

// File: rtl/stk_alu_ptr.sv
module stk_alu_ptr #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end

  // R9
  ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(we)) |-> (q == $past(d)));
endmodule

// File: rtl/stk_alu.sv
module stk_alu
  import stk_alu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [4:0]    cmd,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [DW-1:0] flags_in,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic [DW-1:0] flags_out,
  output logic          flags_we,
  output logic          illegal
);
  logic [DW-1:0] bit_res, sum, flg_nxt, flg_merge;
  logic          bit_hit, cout, flg_we;
  logic          is_add, is_sub, is_frset;
  logic [DW-1:0] res_c;
  logic          legal_c;
  logic [DW-1:0] ptr_q [PTR_CNT];
  logic          ptr_we [PTR_CNT];
  logic [4:0]    q_cmd;

  assign is_add   = (cmd == OP_ADD);
  assign is_sub   = (cmd == OP_SUB);
  assign is_frset = (cmd == OP_FRSET);

  stk_alu_bitops #(.DW(DW)) u_bit (
    .cmd(cmd), .a(opa), .b(opb), .res(bit_res), .hit(bit_hit)
  );

  stk_alu_addsub #(.DW(DW)) u_arith (
    .a(opa), .b(opb), .sub(is_sub), .sum(sum), .cout(cout)
  );

  stk_alu_flags #(.DW(DW)) u_flg (
    .flags_in(flags_in), .a(opa), .keep(opb),
    .do_merge(is_frset), .do_carry(is_add | is_sub), .carry(cout),
    .flags_nxt(flg_nxt), .merged(flg_merge), .we(flg_we)
  );

  assign ptr_we[PTR_SP] = in_valid && !rst && (cmd == OP_SPSET);
  assign ptr_we[PTR_BP] = in_valid && !rst && (cmd == OP_BPSET);

  for (genvar gi = 0; gi < PTR_CNT; gi++) begin : g_ptr
    stk_alu_ptr #(.DW(DW)) u_ptr (
      .clk(clk), .rst(rst), .we(ptr_we[gi]), .d(opa), .q(ptr_q[gi])
    );
  end

  always_comb begin
    legal_c = 1'b1;
    res_c   = '0;
    case (op_e'(cmd))
      OP_FRGET: res_c = flags_in;
      OP_FRSET: res_c = flg_merge;
      OP_BPGET: res_c = ptr_q[PTR_BP];
      OP_SPGET: res_c = ptr_q[PTR_SP];
      OP_BPSET: res_c = opa;
      OP_SPSET: res_c = opa;
      OP_ADD:   res_c = sum;
      OP_SUB:   res_c = sum;
      default: begin
        legal_c = bit_hit;
        res_c   = bit_hit ? bit_res : '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags_out <= '0;
      flags_we  <= 1'b0;
      illegal   <= 1'b0;
      q_cmd     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= res_c;
        flags_out <= flg_nxt;
        flags_we  <= flg_we && legal_c;
        illegal   <= !legal_c;
        q_cmd     <= cmd;
      end else begin
        flags_we <= 1'b0;
        illegal  <= 1'b0;
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  // R10
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (result == '0 && !flags_we));

  // R7
  frset_rsv_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && q_cmd == OP_FRSET) |->
      (flags_we && result == flags_out && flags_out[DW-1:FLG_USED] == '0));

  // R11
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && out_valid && !flags_we) |-> (flags_out == $past(flags_in)));
endmodule

// File: tb/sim_stk_alu.sv
module sim_stk_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [4:0]  cmd = '0;
  logic [15:0] opa = '0, opb = '0, flags_in = '0;
  logic        out_valid, flags_we, illegal;
  logic [15:0] result, flags_out;

  typedef struct packed {
    logic [15:0] res;
    logic [15:0] fl;
    logic        fwe;
    logic        ill;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    total = 0, bad = 0;
  bit    finished = 1'b0;
  logic [15:0] m_sp = '0, m_bp = '0;

  always #5 clk = ~clk;

  stk_alu u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cmd(cmd), .opa(opa), .opb(opb),
    .flags_in(flags_in), .out_valid(out_valid), .result(result),
    .flags_out(flags_out), .flags_we(flags_we), .illegal(illegal)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [4:0] c, input logic [15:0] a,
                                 input logic [15:0] b, input logic [15:0] f);
    exp_t e;
    logic [16:0] w;
    e.res = '0; e.fl = f; e.fwe = 1'b0; e.ill = 1'b0;
    case (c)
      5'd0:  e.res = a;
      5'd10: e.res = f;
      5'd11: begin
        e.res = ((f & b) | (a & ~b)) & 16'h00FF;
        e.fl = e.res; e.fwe = 1'b1;
      end
      5'd12: e.res = m_bp;
      5'd13: e.res = a;
      5'd14: e.res = m_sp;
      5'd15: e.res = a;
      5'd16: begin
        w = 17'(a) + 17'(b);
        e.res = w[15:0]; e.fl[2] = w[16]; e.fwe = 1'b1;
      end
      5'd17: begin
        e.res = a - b; e.fl[2] = (a < b); e.fwe = 1'b1;
      end
      5'd21: e.res = a & b;
      5'd22: e.res = a | b;
      5'd23: e.res = a ^ b;
      5'd24: e.res = ~a;
      5'd25: e.res = {{8{a[7]}}, a[7:0]};
      5'd28: e.res = {a[7:0], a[15:8]};
      5'd30: e.res = a << 1;
      5'd31: e.res = a >> 1;
      default: e.ill = 1'b1;
    endcase
    return e;
  endfunction

  task automatic issue(input string tag, input logic [4:0] c, input logic [15:0] a,
                       input logic [15:0] b, input logic [15:0] f);
    @(negedge clk);
    expq.push_back(model(c, a, b, f));
    tagq.push_back(tag);
    if (c == 5'd15) m_sp = a;
    if (c == 5'd13) m_bp = a;
    in_valid = 1'b1; cmd = c; opa = a; opb = b; flags_in = f;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (expq.size() == 0) begin
        check("R1 unexpected out_valid", 32'(out_valid), 32'd0);
      end else begin
        exp_t  e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check({t, " result"}, 32'(result), 32'(e.res));
        check({t, " flags_we R11"}, 32'(flags_we), 32'(e.fwe));
        check({t, " flags_out R11"}, 32'(flags_out), 32'(e.fl));
        check({t, " illegal R10"}, 32'(illegal), 32'(e.ill));
      end
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 out_valid after reset", 32'(out_valid), 32'd0);
    check("R1 result after reset", 32'(result), 32'd0);
    check("R1 flags_we after reset", 32'(flags_we), 32'd0);
    check("R1 illegal after reset", 32'(illegal), 32'd0);
    issue("R1 R9 spget after reset", 5'd14, 16'hAAAA, 16'h0, 16'h0);
    issue("R1 R9 bpget after reset", 5'd12, 16'h5555, 16'h0, 16'h0);
    // R2 add
    issue("R2 add overflow", 5'd16, 16'h0001, 16'hFFFF, 16'h0000);
    issue("R2 add no carry clears", 5'd16, 16'h1234, 16'h1111, 16'h00FF);
    issue("R2 add max", 5'd16, 16'hFFFF, 16'hFFFF, 16'hFF00);
    // R3 sub
    issue("R3 sub borrow", 5'd17, 16'h0005, 16'h0007, 16'h0000);
    issue("R3 sub plain", 5'd17, 16'h0007, 16'h0005, 16'h0004);
    issue("R3 sub equal", 5'd17, 16'h8000, 16'h8000, 16'h0004);
    // R4 logic
    issue("R4 copy", 5'd0, 16'hBEEF, 16'h1234, 16'h0013);
    issue("R4 and", 5'd21, 16'hF0F0, 16'h3C3C, 16'h0);
    issue("R4 or", 5'd22, 16'hF0F0, 16'h3C3C, 16'h0);
    issue("R4 xor", 5'd23, 16'hF0F0, 16'h3C3C, 16'h0);
    issue("R4 not", 5'd24, 16'h00FF, 16'h0, 16'h0);
    // R5 bytes
    issue("R5 bswap", 5'd28, 16'h12AB, 16'h0, 16'h0);
    issue("R5 signext neg", 5'd25, 16'h1280, 16'h0, 16'h0);
    issue("R5 signext pos", 5'd25, 16'hFF7F, 16'h0, 16'h0);
    // R6 shifts
    issue("R6 lsl", 5'd30, 16'h8001, 16'h0, 16'h0);
    issue("R6 lsr", 5'd31, 16'h8001, 16'h0, 16'h0);
    // R7 flag merge
    issue("R7 frset mask", 5'd11, 16'hFF0A, 16'h000F, 16'h00F5);
    issue("R7 frset keep all", 5'd11, 16'h0000, 16'hFFFF, 16'hFFA5);
    issue("R7 frset take all", 5'd11, 16'hFFFF, 16'h0000, 16'h0000);
    // R8
    issue("R8 frget", 5'd10, 16'h1111, 16'h2222, 16'h00C3);
    // R9 pointers
    issue("R9 spset", 5'd15, 16'h1000, 16'h0, 16'h0);
    issue("R9 bpset", 5'd13, 16'h2000, 16'h0, 16'h0);
    issue("R9 spget", 5'd14, 16'h0, 16'h0, 16'h0);
    issue("R9 bpget", 5'd12, 16'h0, 16'h0, 16'h0);
    // R10 illegal codes, then pointers unchanged
    for (int k = 1; k < 32; k++) begin
      if ((k >= 1 && k <= 9) || (k >= 18 && k <= 20) || k == 26 || k == 27 || k == 29)
        issue("R10 illegal code", 5'(k), 16'h7777, 16'h0F0F, 16'h0033);
    end
    issue("R10 spget after illegal", 5'd14, 16'h0, 16'h0, 16'h0);
    // R11 random mix
    for (int k = 0; k < 300; k++) begin
      issue("R11 random", 5'($urandom_range(0, 31)), 16'($urandom), 16'($urandom),
            16'($urandom));
    end
    repeat (3) @(negedge clk);
    check("R1 all results seen", 32'(expq.size()), 32'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule